// File: doc/BRIEF.md
# SMRAM Control Register and Address Decoder

This block holds one 8-bit control register for an extended system-management memory region and the address decode that the register drives. Software reads and writes the register through a simple port with a byte write strobe. The decode watches every processor address that carries a valid strobe and does two things. It folds a 128 KB high window down onto the legacy low SMRAM area. It also marks a carve-out just below top of memory so that those accesses go to the downstream hub and not to local memory.

A lock input freezes the configuration fields. A sticky violation flag records any access to an enabled region from outside system-management mode while the region is not held open. Software clears that flag by writing a one to it. The remap and forward outputs are combinational from the address. The violation flag is registered.

Top module: `smram_ctrl_decoder`

## Requirements
- R1: After reset the register reads 0x38 and the violation flag output is 0.
- R2: Bits 5, 4 and 3 always read 1, and writes to them have no effect.
- R3: While unlocked, a write stores bit 7 (high window enable), bits 2:1 (carve-out size) and bit 0 (carve-out enable), and a read returns them in those positions.
- R4: A write is blocked for bits 7, 2:1 and 0 in any cycle where the lock input is high. The lock then stays in force until reset, even after the input falls.
- R5: Bit 6 (violation flag) is cleared by a write with bit 6 = 1, and the clear works while locked. A write with bit 6 = 0 leaves it unchanged.
- R6: On the clock edge after a valid access that hits an enabled region with SMM mode = 0 and open = 0, bit 6 and the flag output become 1. With SMM mode = 1 or open = 1 the flag is not set.
- R7: When a violation and a write-one-to-clear fall in the same cycle, the flag ends up set.
- R8: With global enable = 1, bit 7 = 1 and a valid address in 0xFEDA0000–0xFEDBFFFF, the memory address output is 0x000A0000 plus the offset into the window, and the remap indicator is 1.
- R9: With global enable = 1, bit 0 = 1 and size code 2'b10 (512 KB) or 2'b11 (1 MB), a valid address in [TOM − size, TOM) raises the forward output. The upper bound TOM is exclusive.
- R10: Size codes 2'b00 and 2'b01 disable the carve-out decode: no forward and no violation.
- R11: An address outside both enabled regions, or any address without the valid strobe, passes through unchanged, with forward and remap both 0.
- R12: With global enable = 0, neither region is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Byte write strobe for the register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Register read value |
| smram_glb_en | input | 1 | Global SMRAM enable |
| lock_in | input | 1 | Configuration lock request |
| open_in | input | 1 | SMRAM held open |
| smm_mode | input | 1 | Processor is in system-management mode |
| tom | input | ADDR_W | Top of memory, exclusive |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_valid | input | 1 | Address valid strobe |
| mem_addr | output | ADDR_W | Address after remap |
| remap_hit | output | 1 | High window remap applied |
| fwd_hub | output | 1 | Send the access to the hub instead of local memory |
| err_flag | output | 1 | Sticky violation flag |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 128 KB high window, and carve-out sizes of 512 KB and 1 MB. Top of memory is tied to 0x10000000, so both carve-out lower edges, the exclusive top edge and both ends of the high window can each be hit by exact addresses. Lock, clear and violation events are placed in shared cycles, which exposes the same-cycle lock block and the set-over-clear priority.

// File: rtl/smram_pkg.sv
package smram_pkg;

    // register field positions used by the read/write path
    localparam int unsigned BIT_HIGH_EN = 7;
    localparam int unsigned BIT_ERR     = 6;
    localparam int unsigned BIT_EN      = 0;
    localparam logic [2:0]  FIXED_ONES  = 3'b111;

    typedef struct packed {
        logic       lock;
        logic       high_en;
        logic       err;
        logic [1:0] tseg_sz;
        logic       tseg_en;
    } cfg_state_t;

    localparam cfg_state_t CFG_RESET = '{lock: 1'b0, high_en: 1'b0, err: 1'b0,
                                         tseg_sz: 2'b00, tseg_en: 1'b0};

endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
    import smram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       lock_in,
    input  logic       illegal_i,
    output logic [7:0] rdata_o,
    output logic       high_en_o,
    output logic [1:0] tseg_sz_o,
    output logic       tseg_en_o,
    output logic       err_o
);

    cfg_state_t st_d, st_q;
    logic       locked_now;
    logic       unused_wbits;

    assign unused_wbits = ^wdata[5:3];
    assign locked_now   = st_q.lock | lock_in;

    always_comb begin
        st_d      = st_q;
        st_d.lock = locked_now;
        if (wr_en) begin
            if (!locked_now) begin
                st_d.high_en = wdata[BIT_HIGH_EN];
                st_d.tseg_sz = wdata[2:1];
                st_d.tseg_en = wdata[BIT_EN];
            end
            if (wdata[BIT_ERR]) begin
                st_d.err = 1'b0;
            end
        end
        // a violation in the same cycle overrides the clear
        if (illegal_i) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = {st_q.high_en, st_q.err, FIXED_ONES, st_q.tseg_sz, st_q.tseg_en};
    assign high_en_o = st_q.high_en;
    assign tseg_sz_o = st_q.tseg_sz;
    assign tseg_en_o = st_q.tseg_en;
    assign err_o     = st_q.err;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R4
    AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable({st_q.high_en, st_q.tseg_sz, st_q.tseg_en})); // R4
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_i |=> st_q.err); // R6
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !(wr_en && wdata[BIT_ERR])) |=> st_q.err); // R5

endmodule

// File: rtl/smram_decode.sv
module smram_decode #(
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        WIN_LOG2   = 17,
    parameter logic [ADDR_W-1:0]  HIGH_BASE  = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0]  LOW_BASE   = 32'h000A_0000,
    parameter int unsigned        SMALL_LOG2 = 19,
    parameter int unsigned        LARGE_LOG2 = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              valid_i,
    input  logic              glb_en_i,
    input  logic              high_en_i,
    input  logic              tseg_en_i,
    input  logic [1:0]        tseg_sz_i,
    input  logic [ADDR_W-1:0] tom_i,
    input  logic              smm_i,
    input  logic              open_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              remap_o,
    output logic              fwd_o,
    output logic              illegal_o
);

    localparam logic [ADDR_W-1:0] SMALL_BYTES = ADDR_W'(1) << SMALL_LOG2;
    localparam logic [ADDR_W-1:0] LARGE_BYTES = ADDR_W'(1) << LARGE_LOG2;
    localparam int unsigned       TAG_W       = ADDR_W - WIN_LOG2;

    logic              in_high;
    logic              high_act;
    logic              tseg_act;
    logic [ADDR_W-1:0] tseg_size;
    logic [ADDR_W-1:0] tseg_base;
    logic              in_tseg;
    logic              region_hit;

    always_comb begin
        in_high   = (addr_i[ADDR_W-1 -: TAG_W] == HIGH_BASE[ADDR_W-1 -: TAG_W]);
        high_act  = glb_en_i & high_en_i;
        // only size codes with the top bit set describe a window
        tseg_act  = glb_en_i & tseg_en_i & tseg_sz_i[1];
        tseg_size = tseg_sz_i[0] ? LARGE_BYTES : SMALL_BYTES;
        tseg_base = (tom_i >= tseg_size) ? (tom_i - tseg_size) : '0;
        in_tseg   = (addr_i >= tseg_base) && (addr_i < tom_i);

        remap_o    = valid_i & high_act & in_high;
        fwd_o      = valid_i & tseg_act & in_tseg;
        region_hit = remap_o | fwd_o;
        illegal_o  = region_hit & ~smm_i & ~open_i;

        mem_addr_o = addr_i;
        if (remap_o) begin
            mem_addr_o = {LOW_BASE[ADDR_W-1 -: TAG_W], addr_i[WIN_LOG2-1:0]};
        end
    end

endmodule

// File: rtl/smram_ctrl_decoder.sv
module smram_ctrl_decoder #(
    parameter int unsigned        ADDR_W     = 32,
    parameter int unsigned        WIN_LOG2   = 17,
    parameter logic [ADDR_W-1:0]  HIGH_BASE  = 32'hFEDA_0000,
    parameter logic [ADDR_W-1:0]  LOW_BASE   = 32'h000A_0000,
    parameter int unsigned        SMALL_LOG2 = 19,
    parameter int unsigned        LARGE_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smram_glb_en,
    input  logic              lock_in,
    input  logic              open_in,
    input  logic              smm_mode,
    input  logic [ADDR_W-1:0] tom,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              remap_hit,
    output logic              fwd_hub,
    output logic              err_flag
);

    logic       high_en;
    logic       tseg_en;
    logic [1:0] tseg_sz;
    logic       illegal;

    smram_cfg_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wdata     (cfg_wdata),
        .lock_in   (lock_in),
        .illegal_i (illegal),
        .rdata_o   (cfg_rdata),
        .high_en_o (high_en),
        .tseg_sz_o (tseg_sz),
        .tseg_en_o (tseg_en),
        .err_o     (err_flag)
    );

    smram_decode #(
        .ADDR_W     (ADDR_W),
        .WIN_LOG2   (WIN_LOG2),
        .HIGH_BASE  (HIGH_BASE),
        .LOW_BASE   (LOW_BASE),
        .SMALL_LOG2 (SMALL_LOG2),
        .LARGE_LOG2 (LARGE_LOG2)
    ) u_dec (
        .addr_i     (cpu_addr),
        .valid_i    (cpu_valid),
        .glb_en_i   (smram_glb_en),
        .high_en_i  (high_en),
        .tseg_en_i  (tseg_en),
        .tseg_sz_i  (tseg_sz),
        .tom_i      (tom),
        .smm_i      (smm_mode),
        .open_i     (open_in),
        .mem_addr_o (mem_addr),
        .remap_o    (remap_hit),
        .fwd_o      (fwd_hub),
        .illegal_o  (illegal)
    );

    AST_FWD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hub |-> (cpu_valid && smram_glb_en && cfg_rdata[0])); // R9
    AST_REMAP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (cpu_valid && smram_glb_en && cfg_rdata[7])); // R12
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !remap_hit |-> (mem_addr == cpu_addr)); // R11
    AST_REMAP_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        remap_hit |-> (mem_addr[WIN_LOG2-1:0] == cpu_addr[WIN_LOG2-1:0])); // R8
    AST_NO_FWD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[2] |-> !fwd_hub); // R10

endmodule

// File: tb/tb_smram_ctrl_decoder.sv
module tb_smram_ctrl_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        smram_glb_en = 1'b0;
    logic        lock_in = 1'b0;
    logic        open_in = 1'b0;
    logic        smm_mode = 1'b1;
    logic [31:0] tom = 32'h1000_0000;
    logic [31:0] cpu_addr = '0;
    logic        cpu_valid = 1'b0;
    logic [31:0] mem_addr;
    logic        remap_hit;
    logic        fwd_hub;
    logic        err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    smram_ctrl_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .smram_glb_en(smram_glb_en), .lock_in(lock_in),
        .open_in(open_in), .smm_mode(smm_mode), .tom(tom), .cpu_addr(cpu_addr),
        .cpu_valid(cpu_valid), .mem_addr(mem_addr), .remap_hit(remap_hit),
        .fwd_hub(fwd_hub), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic        glb;
        logic        vld;
        logic [31:0] addr;
        logic [31:0] exp_addr;
        logic        exp_fwd;
        logic        exp_hit;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{8'h81, 1'b1, 1'b1, 32'hFEDA_0000, 32'h000A_0000, 1'b0, 1'b1}, // R8 low edge
        '{8'h81, 1'b1, 1'b1, 32'hFEDB_FFFF, 32'h000B_FFFF, 1'b0, 1'b1}, // R8 high edge
        '{8'h81, 1'b1, 1'b1, 32'hFEDC_0000, 32'hFEDC_0000, 1'b0, 1'b0}, // R11 past window
        '{8'h05, 1'b1, 1'b1, 32'h0FF8_0000, 32'h0FF8_0000, 1'b1, 1'b0}, // R9 512K base
        '{8'h05, 1'b1, 1'b1, 32'h0FF7_FFFF, 32'h0FF7_FFFF, 1'b0, 1'b0}, // R9 below base
        '{8'h07, 1'b1, 1'b1, 32'h0FF0_0000, 32'h0FF0_0000, 1'b1, 1'b0}, // R9 1M base
        '{8'h07, 1'b1, 1'b1, 32'h1000_0000, 32'h1000_0000, 1'b0, 1'b0}, // R9 TOM exclusive
        '{8'h03, 1'b1, 1'b1, 32'h0FFF_FFFF, 32'h0FFF_FFFF, 1'b0, 1'b0}, // R10 reserved
        '{8'h81, 1'b0, 1'b1, 32'hFEDA_1234, 32'hFEDA_1234, 1'b0, 1'b0}, // R12 global off
        '{8'h81, 1'b1, 1'b0, 32'hFEDA_1234, 32'hFEDA_1234, 1'b0, 1'b0}  // R11 no valid
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a);
        @(negedge clk);
        cpu_addr = a;
        cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", {24'h0, cfg_rdata}, 32'h38);
        check("R1 flag clear", {31'h0, err_flag}, 32'h0);

        // table walk, SMM mode held high so no violations arise
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].cfg);
            smram_glb_en = VEC[i].glb;
            cpu_valid    = VEC[i].vld;
            cpu_addr     = VEC[i].addr;
            #1;
            check($sformatf("vec %0d addr", i), mem_addr, VEC[i].exp_addr);
            check($sformatf("vec %0d fwd", i), {31'h0, fwd_hub}, {31'h0, VEC[i].exp_fwd});
            check($sformatf("vec %0d hit", i), {31'h0, remap_hit}, {31'h0, VEC[i].exp_hit});
            cpu_valid = 1'b0;
        end
        smram_glb_en = 1'b1;

        // R2 R3 field access
        wr(8'hFF);
        check("R3 all writable set", {24'h0, cfg_rdata}, 32'hBF);
        wr(8'h00);
        check("R2 fixed ones kept", {24'h0, cfg_rdata}, 32'h38);

        // R6 violation from outside SMM
        wr(8'h81);
        smm_mode = 1'b0;
        access(32'hFEDA_0000);
        check("R6 flag set", {31'h0, err_flag}, 32'h1);
        wr(8'h81);
        check("R5 write zero keeps flag", {24'h0, cfg_rdata}, 32'hF9);
        wr(8'h40);
        check("R5 w1c clears", {24'h0, cfg_rdata}, 32'h38);

        // R6 no violation in SMM or when open
        wr(8'h81);
        smm_mode = 1'b1;
        access(32'hFEDA_0000);
        check("R6 smm no flag", {31'h0, err_flag}, 32'h0);
        smm_mode = 1'b0;
        open_in = 1'b1;
        access(32'hFEDA_0000);
        check("R6 open no flag", {31'h0, err_flag}, 32'h0);
        open_in = 1'b0;

        // R10 reserved size gives no violation
        wr(8'h03);
        access(32'h0FFF_FFFF);
        check("R10 reserved no flag", {31'h0, err_flag}, 32'h0);

        // R6 violation through the carve-out
        wr(8'h05);
        access(32'h0FF8_0000);
        check("R6 tseg flag", {31'h0, err_flag}, 32'h1);

        // R7 set beats clear in the same cycle
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 8'h45;
        cpu_addr = 32'h0FF8_0000;
        cpu_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cpu_valid = 1'b0;
        check("R7 set wins", {31'h0, err_flag}, 32'h1);
        wr(8'h40);
        check("R5 clear after R7", {31'h0, err_flag}, 32'h0);
        smm_mode = 1'b1;

        // R4 lock in the same cycle as a write
        wr(8'h81);
        @(negedge clk);
        lock_in = 1'b1;
        cfg_we = 1'b1;
        cfg_wdata = 8'h07;
        @(negedge clk);
        cfg_we = 1'b0;
        lock_in = 1'b0;
        check("R4 same-cycle block", {24'h0, cfg_rdata}, 32'hB9);
        wr(8'h07);
        check("R4 sticky lock", {24'h0, cfg_rdata}, 32'hB9);

        // R5 clear works while locked
        smm_mode = 1'b0;
        access(32'hFEDA_0000);
        check("R6 flag while locked", {24'h0, cfg_rdata}, 32'hF9);
        smm_mode = 1'b1;
        wr(8'h40);
        check("R5 clear while locked", {24'h0, cfg_rdata}, 32'hB9);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule